// File: doc/BRIEF.md
# Bus Target for Burst Memory Writes

This block is the target side of a 32-bit parallel bus for burst memory writes. It watches the shared bus for the start of a transaction. It latches the address in the address phase and claims the transaction when the command is a memory write and the address falls inside one base-address window. While the transaction runs, it hands each accepted data word and its byte enables to a local back end.

The back end sees a select line and the captured address. It paces the burst with an active-low ready input. The target turns that ready input into the bus target-ready one clock later. Each word accepted on the bus comes out on the local data and byte-enable outputs one clock after the bus handshake, with an active-low completion strobe. The back end can then store the word and advance its own address counter.

The target claims the bus with slow device-select timing. At the end of the burst it first deasserts its control lines and then releases them. An output-enable models the tri-state drivers.

Top module: `pci_wr_target`

## Requirements
- R1: After reset, and whenever reset is applied in the middle of a transaction, the outputs are idle: `devsel_n`=1, `trdy_n`=1, `ctl_oe`=0, `lcl_hit`=0, `lcl_xfer_n`=1.
- R2: An address phase is the first cycle with `frame_n` low after a cycle with it high. If `cbe_n` is 4'b0111 (memory write) there and `ad` lies in [BAR_BASE, BAR_BASE+BAR_SIZE), then `lcl_hit` rises on the next clock edge and `lcl_addr` holds that address.
- R3: An address phase outside the window, or with any other command, is ignored: `lcl_hit`, `ctl_oe` and `devsel_n` never assert and `lcl_xfer_n` stays high.
- R4: `devsel_n` falls exactly one clock after `lcl_hit` rises.
- R5: While `devsel_n` is low, `trdy_n` in each cycle equals `lcl_rdy_n` as sampled on the previous clock edge. `trdy_n` is never low while `devsel_n` is high.
- R6: A clock edge with `irdy_n` and `trdy_n` both low accepts a word. In the next cycle `lcl_xfer_n` is low, `lcl_data` holds that word's `ad` and `lcl_be_n` holds its `cbe_n`.
- R7: Wait states inserted by the master (`irdy_n` high) or by the back end (`lcl_rdy_n` high) transfer nothing. Each word of a burst is delivered exactly once, in order.
- R8: After the handshake in which `frame_n` is high, the next cycle has `devsel_n`=1, `trdy_n`=1 and `ctl_oe`=1. The cycle after that has `lcl_hit`=0, `ctl_oe`=0 and `lcl_xfer_n`=1.
- R9: `ctl_oe` is high whenever `devsel_n` or `trdy_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Master frame, low during the transaction |
| irdy_n | input | 1 | Master ready |
| ad | input | 32 | Address in the address phase, data in data phases |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables later |
| devsel_n | output | 1 | Device select (registered) |
| trdy_n | output | 1 | Target ready (registered) |
| ctl_oe | output | 1 | Drive enable for devsel_n and trdy_n |
| lcl_rdy_n | input | 1 | Back-end ready, active low |
| lcl_hit | output | 1 | Window hit, back-end chip select |
| lcl_addr | output | 32 | Captured transaction address |
| lcl_data | output | 32 | Last accepted data word |
| lcl_be_n | output | 4 | Byte enables of lcl_data |
| lcl_xfer_n | output | 1 | Word-complete strobe, active low |

## Verification
The bench probes both window edges: the last word inside the window, the first address past it, and one word below the base. A comparator off by one would claim or drop one of these. It also issues a read command into the window, which a decoder that ignores the command would wrongly claim. Patterned stalls from both the master and the back end expose designs that deliver a word twice, drop a word, or assert target-ready without the back end's readiness on the edge before. A single-word burst and the release sequence check the order in which select and output-enable drop. A reset in the middle of a burst must return everything to idle.

// File: rtl/pci_tw_pkg.sv
package pci_tw_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLAIM,
        ST_DATA,
        ST_DONE
    } tw_state_e;

    typedef struct packed {
        tw_state_e           state;
        logic                hit;
        logic [ADDR_W-1:0]   addr;
        logic                devsel_n;
        logic                trdy_n;
        logic                oe;
        logic                frame_prev;
    } tw_ctl_t;

    typedef struct packed {
        logic [DATA_W-1:0]   data;
        logic [BE_W-1:0]     be_n;
        logic                xfer_n;
    } tw_wdata_t;
endpackage

// File: rtl/pci_tw_decode.sv
module pci_tw_decode
    import pci_tw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BAR_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] BAR_SIZE = 32'h0000_1000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        cmd,
    output logic              match
);
    localparam logic [ADDR_W:0] LO_BOUND = {1'b0, BAR_BASE};
    localparam logic [ADDR_W:0] HI_BOUND = {1'b0, BAR_BASE} + {1'b0, BAR_SIZE};

    logic [ADDR_W:0] addr_ext;
    logic            in_window;
    logic            cmd_ok;

    always_comb begin
        addr_ext  = {1'b0, addr};
        in_window = (addr_ext >= LO_BOUND) && (addr_ext < HI_BOUND);
        cmd_ok    = (cmd == CMD_MEM_WRITE);
        match     = in_window && cmd_ok;
    end
endmodule

// File: rtl/pci_tw_wdata.sv
module pci_tw_wdata
    import pci_tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] ad,
    input  logic [BE_W-1:0]   cbe_n,
    output logic [DATA_W-1:0] data,
    output logic [BE_W-1:0]   be_n,
    output logic              xfer_n
);
    tw_wdata_t wd_d, wd_q;

    always_comb begin
        wd_d        = wd_q;
        wd_d.xfer_n = 1'b1;
        if (capture) begin
            wd_d.data   = ad;
            wd_d.be_n   = cbe_n;
            wd_d.xfer_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q.data   <= '0;
            wd_q.be_n   <= '1;
            wd_q.xfer_n <= 1'b1;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign data   = wd_q.data;
    assign be_n   = wd_q.be_n;
    assign xfer_n = wd_q.xfer_n;
endmodule

// File: rtl/pci_wr_target.sv
module pci_wr_target
    import pci_tw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BAR_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] BAR_SIZE = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [ADDR_W-1:0] ad,
    input  logic [3:0]        cbe_n,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              ctl_oe,
    input  logic              lcl_rdy_n,
    output logic              lcl_hit,
    output logic [ADDR_W-1:0] lcl_addr,
    output logic [DATA_W-1:0] lcl_data,
    output logic [BE_W-1:0]   lcl_be_n,
    output logic              lcl_xfer_n
);
    localparam logic [ADDR_W:0] WIN_LO = {1'b0, BAR_BASE};
    localparam logic [ADDR_W:0] WIN_HI = {1'b0, BAR_BASE} + {1'b0, BAR_SIZE};

    tw_ctl_t ctl_d, ctl_q;
    logic    addr_match;
    logic    start_seen;
    logic    handshake;

    pci_tw_decode #(
        .BAR_BASE (BAR_BASE),
        .BAR_SIZE (BAR_SIZE)
    ) u_decode (
        .addr  (ad),
        .cmd   (cbe_n),
        .match (addr_match)
    );

    always_comb begin
        start_seen = !frame_n && ctl_q.frame_prev;
        handshake  = (ctl_q.state == ST_DATA) && !irdy_n && !ctl_q.trdy_n;
    end

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.frame_prev = frame_n;
        unique case (ctl_q.state)
            ST_IDLE: begin
                ctl_d.hit      = 1'b0;
                ctl_d.devsel_n = 1'b1;
                ctl_d.trdy_n   = 1'b1;
                ctl_d.oe       = 1'b0;
                if (start_seen && addr_match) begin
                    ctl_d.addr  = ad;
                    ctl_d.hit   = 1'b1;
                    ctl_d.state = ST_CLAIM;
                end
            end
            ST_CLAIM: begin
                ctl_d.devsel_n = 1'b0;
                ctl_d.oe       = 1'b1;
                ctl_d.trdy_n   = lcl_rdy_n;
                ctl_d.state    = ST_DATA;
            end
            ST_DATA: begin
                if (handshake && frame_n) begin
                    ctl_d.devsel_n = 1'b1;
                    ctl_d.trdy_n   = 1'b1;
                    ctl_d.state    = ST_DONE;
                end else begin
                    ctl_d.trdy_n = lcl_rdy_n;
                end
            end
            ST_DONE: begin
                ctl_d.hit   = 1'b0;
                ctl_d.oe    = 1'b0;
                ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state      <= ST_IDLE;
            ctl_q.hit        <= 1'b0;
            ctl_q.addr       <= '0;
            ctl_q.devsel_n   <= 1'b1;
            ctl_q.trdy_n     <= 1'b1;
            ctl_q.oe         <= 1'b0;
            ctl_q.frame_prev <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pci_tw_wdata u_wdata (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (handshake),
        .ad      (ad),
        .cbe_n   (cbe_n),
        .data    (lcl_data),
        .be_n    (lcl_be_n),
        .xfer_n  (lcl_xfer_n)
    );

    assign devsel_n = ctl_q.devsel_n;
    assign trdy_n   = ctl_q.trdy_n;
    assign ctl_oe   = ctl_q.oe;
    assign lcl_hit  = ctl_q.hit;
    assign lcl_addr = ctl_q.addr;

    // R2: a held select always carries an address inside the window
    assert_hit_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_hit |-> ({1'b0, lcl_addr} >= WIN_LO) && ({1'b0, lcl_addr} < WIN_HI));

    // R4: slow claim, select follows the hit by one clock
    assert_devsel_slow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcl_hit) |=> !devsel_n);

    // R5: target ready only after back-end ready on the previous edge
    assert_trdy_follows_rdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> $past(!lcl_rdy_n));

    // R6: each local strobe comes from a bus handshake one clock earlier
    assert_strobe_after_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lcl_xfer_n |-> $past(!irdy_n && !trdy_n));

    // R8: select drops together with the drivers, after devsel was released
    assert_release_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcl_hit) |-> !ctl_oe && $past(devsel_n) && $past(ctl_oe));

    // R9: active control lines are always driven
    assert_driven_when_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n || !devsel_n) |-> ctl_oe);
endmodule

// File: tb/sim_pci_wr_target.sv
module sim_pci_wr_target;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam logic [31:0] SIZE = 32'h0000_1000;

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  cmd;
        logic [3:0]  nw;
        logic [7:0]  rdy;
        logic [7:0]  mw;
        logic        hit;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h4000_0010, 4'b0111, 4'd3, 8'h00,        8'h00,        1'b1},
        '{32'h4000_0FFC, 4'b0111, 4'd4, 8'b0010_0110, 8'b0000_0010, 1'b1},
        '{32'h4000_1000, 4'b0111, 4'd2, 8'h00,        8'h00,        1'b0},
        '{32'h3FFF_FFFC, 4'b0111, 4'd2, 8'h00,        8'h00,        1'b0},
        '{32'h4000_0000, 4'b0110, 4'd2, 8'h00,        8'h00,        1'b0},
        '{32'h4000_0800, 4'b0111, 4'd1, 8'b0101_0101, 8'b0000_0001, 1'b1},
        '{32'h4000_0400, 4'b0111, 4'd6, 8'b1100_1100, 8'b0010_0100, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        lcl_rdy_n = 1'b1;
    logic        devsel_n, trdy_n, ctl_oe, lcl_hit, lcl_xfer_n;
    logic [31:0] lcl_addr, lcl_data;
    logic [3:0]  lcl_be_n;

    pci_wr_target #(.BAR_BASE(BASE), .BAR_SIZE(SIZE)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad(ad), .cbe_n(cbe_n), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .ctl_oe(ctl_oe), .lcl_rdy_n(lcl_rdy_n), .lcl_hit(lcl_hit),
        .lcl_addr(lcl_addr), .lcl_data(lcl_data), .lcl_be_n(lcl_be_n),
        .lcl_xfer_n(lcl_xfer_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int vi, input int k);
        return {8'hC0 + 8'(vi), 8'(k), 16'h5A00 | 16'(k)};
    endfunction

    function automatic logic [3:0] be_of(input int vi, input int k);
        return 4'(k * 5 + vi + 2);
    endfunction

    // monitor state
    logic [7:0]  rdy_pat = 8'h00;
    int          cyc = 0;
    logic        rdy_e = 1'b1;
    logic        frame_prev = 1'b1;
    int          start_cyc = -10, fin_cyc = -10, hit_rise = -10, devsel_on = -10;
    logic [31:0] addr_at_rise = '0;
    logic        hit_prev = 1'b0, devsel_prev = 1'b1, trdy_s = 1'b1;
    int          cap_n = 0;
    logic [31:0] cap_d [16];
    logic [3:0]  cap_be [16];
    bit          r5_bad = 0, r9_bad = 0, rel1 = 0, rel2 = 0;
    bit          hit_seen = 0, dev_seen = 0, oe_seen = 0;

    task automatic clear_mon();
        start_cyc = -10; fin_cyc = -10; hit_rise = -10; devsel_on = -10;
        cap_n = 0; r5_bad = 0; r9_bad = 0; rel1 = 0; rel2 = 0;
        hit_seen = 0; dev_seen = 0; oe_seen = 0;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            lcl_rdy_n = rdy_pat[cyc[2:0]];
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            rdy_e = lcl_rdy_n;
            if (!frame_n && frame_prev) start_cyc = cyc;
            if (rst_n && !irdy_n && !trdy_s && frame_n) fin_cyc = cyc;
            frame_prev = frame_n;
            @(negedge clk);
            trdy_s = trdy_n;
            if (lcl_hit && !hit_prev) begin hit_rise = cyc; addr_at_rise = lcl_addr; end
            if (!devsel_n && devsel_prev) devsel_on = cyc;
            hit_prev = lcl_hit;
            devsel_prev = devsel_n;
            if (lcl_hit) hit_seen = 1;
            if (!devsel_n) dev_seen = 1;
            if (ctl_oe) oe_seen = 1;
            if (!lcl_xfer_n && cap_n < 16) begin
                cap_d[cap_n] = lcl_data;
                cap_be[cap_n] = lcl_be_n;
                cap_n++;
            end
            if (!devsel_n && (trdy_n != rdy_e)) r5_bad = 1;
            if (devsel_n && !trdy_n) r5_bad = 1;
            if ((!devsel_n || !trdy_n) && !ctl_oe) r9_bad = 1;
            if (cyc == fin_cyc) rel1 = devsel_n && trdy_n && ctl_oe;
            if (cyc == fin_cyc + 1) rel2 = !lcl_hit && !ctl_oe && lcl_xfer_n;
        end
    end

    task automatic run_txn(input vec_t v, input int vi);
        rdy_pat = v.rdy;
        clear_mon();
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad = v.addr; cbe_n = v.cmd;
        if (v.hit) begin
            for (int k = 0; k < int'(v.nw); k++) begin
                @(negedge clk);
                if (v.mw[k]) begin
                    irdy_n = 1'b1; ad = 32'hDEAD_0000; cbe_n = 4'hF;
                    @(negedge clk);
                end
                irdy_n = 1'b0; ad = word_of(vi, k); cbe_n = be_of(vi, k);
                frame_n = (k == int'(v.nw) - 1);
                for (int g = 0; g < 40 && trdy_n !== 1'b0; g++) @(negedge clk);
            end
            @(negedge clk);
        end else begin
            @(negedge clk);
            frame_n = 1'b1; irdy_n = 1'b0; ad = word_of(vi, 0); cbe_n = be_of(vi, 0);
            repeat (5) @(negedge clk);
        end
        frame_n = 1'b1; irdy_n = 1'b1; ad = '0; cbe_n = 4'hF;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_vec(input vec_t v, input int vi);
        if (v.hit) begin
            chk(hit_rise == start_cyc, "R2 hit timing", 32'(hit_rise), 32'(start_cyc));
            chk(addr_at_rise == v.addr, "R2 address", addr_at_rise, v.addr);
            chk(devsel_on == start_cyc + 1, "R4 devsel slow", 32'(devsel_on), 32'(start_cyc + 1));
            chk(!r5_bad, "R5 trdy vs ready", 32'(r5_bad), 32'd0);
            chk(cap_n == int'(v.nw), "R7 word count", 32'(cap_n), 32'(v.nw));
            for (int k = 0; k < int'(v.nw) && k < cap_n; k++) begin
                chk(cap_d[k] == word_of(vi, k), "R6 data", cap_d[k], word_of(vi, k));
                chk(cap_be[k] == be_of(vi, k), "R6 byte enables", 32'(cap_be[k]), 32'(be_of(vi, k)));
            end
            chk(rel1, "R8 deassert step", 32'(rel1), 32'd1);
            chk(rel2, "R8 release step", 32'(rel2), 32'd1);
            chk(!r9_bad, "R9 drive enable", 32'(r9_bad), 32'd0);
        end else begin
            chk(!hit_seen, "R3 no hit", 32'(hit_seen), 32'd0);
            chk(!dev_seen && !oe_seen, "R3 no claim", {30'd0, dev_seen, oe_seen}, 32'd0);
            chk(cap_n == 0, "R3 no strobe", 32'(cap_n), 32'd0);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(devsel_n && trdy_n && !ctl_oe && !lcl_hit && lcl_xfer_n, tag,
            {27'd0, devsel_n, trdy_n, ctl_oe, lcl_hit, lcl_xfer_n}, 32'b11001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 reset state");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R1 idle after reset");

        for (int i = 0; i < NV; i++) begin
            run_txn(VECS[i], i);
            check_vec(VECS[i], i);
        end

        // R1: reset in the middle of a burst
        rdy_pat = 8'h00;
        @(negedge clk);
        frame_n = 1'b0; ad = 32'h4000_0100; cbe_n = 4'b0111;
        @(negedge clk);
        irdy_n = 1'b0; ad = 32'h1234_5678; cbe_n = 4'h0;
        repeat (2) @(negedge clk);
        chk(!devsel_n, "R1 burst running before reset", 32'(devsel_n), 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 mid-burst reset");
        frame_n = 1'b1; irdy_n = 1'b1; ad = '0; cbe_n = 4'hF;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R1 idle after mid-burst reset");

        // recovery: a normal burst still works
        run_txn(VECS[0], 0);
        check_vec(VECS[0], 0);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog R-all act=timeout exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule